// File: doc/BRIEF.md
# Row-Buffered Nonvolatile Write Controller

This block sits between a serial register front end and a byte-addressed storage array that models nonvolatile memory organised in rows of eight bytes. The front end hands it one byte-write strobe per data byte, with the full address and the data, and a one-cycle pulse when the bus transaction ends. The first byte of a transaction loads a row buffer with the current contents of the addressed row. That byte and every later byte of the same transaction are merged into the buffer at the low three address bits. The row selected by the first byte stays fixed until the transaction ends.

When the end-of-transaction pulse arrives after at least one accepted byte, the controller commits the whole buffered row to the array. It holds `busy` high for a fixed, parameterised number of clock cycles while it does so. The front end uses `busy` to refuse its device address, so a host may poll by addressing the device repeatedly. All eight bytes of the row are written on the last busy cycle, and bytes that were not written in the transaction keep their old values. A separate combinational read port returns any stored byte at any time.

Top module: `nvrow_writer`

## Requirements
- R1: After reset `busy` is 0 and every byte of the array reads 8'hFF.
- R2: The first accepted strobe of a transaction loads the buffer from array row `wr_addr[7:3]` and places `wr_data` at offset `wr_addr[2:0]`. Later strobes in the same transaction write at their offset `wr_addr[2:0]` within that latched row, and their bits 7..3 are ignored.
- R3: A commit starts only on a `stop_pulse` that follows, or coincides with, at least one accepted strobe. Until the commit ends the array is unchanged.
- R4: A `stop_pulse` with no accepted strobe since the last commit (an address-only transaction) does not raise `busy` and does not change the array.
- R5: `busy` rises in the cycle after the `stop_pulse` is sampled and stays high for exactly WRITE_CYCLES cycles.
- R6: A commit writes all eight bytes of the latched row. Bytes not written in the transaction keep their previous values.
- R7: While `busy` is high, the read port returns the old row contents. The new values appear in the first cycle in which `busy` is low.
- R8: Strobes and `stop_pulse` that arrive while `busy` is high are ignored. They change neither the array nor any later transaction.
- R9: A strobe in the first cycle after `busy` falls is accepted and opens a new transaction (acknowledge polling).
- R10: Two strobes to the same offset in one transaction leave the later data in the row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Byte-write strobe from the front end |
| wr_addr | input | 8 | Byte address of the strobe |
| wr_data | input | 8 | Data byte of the strobe |
| stop_pulse | input | 1 | One-cycle end-of-transaction pulse |
| rd_addr | input | 8 | Read port byte address |
| rd_data | output | 8 | Stored byte at `rd_addr` (combinational) |
| busy | output | 1 | High while a row commit is in progress |

## Verification
The main risk is a wrong internal state, and it shows at the ports in two ways. A stale buffer, a wrong latched row index or a commit that was never started appears only as wrong `rd_data` once `busy` falls. A timer that is off by one, or a transaction state that is wrongly left open, appears as a `busy` edge one cycle early or late, or as `busy` rising when it should not. The reference model predicts both `busy` and the read byte on every cycle, so these errors are caught in the first cycle after the affected commit ends. The read address is swept across the written rows so that the neighbouring bytes are also compared.

// File: rtl/nvrow_pkg.sv
package nvrow_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_COMMIT = 2'd2
  } wr_state_e;
endpackage

// File: rtl/nvrow_store.sv
module nvrow_store #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ROW_BYTES = 8,
  parameter int unsigned ERASED    = 255,
  localparam int unsigned OFS_W    = $clog2(ROW_BYTES),
  localparam int unsigned ROW_W    = ADDR_W - OFS_W,
  localparam int unsigned ROWS     = 1 << ROW_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ROW_W-1:0]                  row_sel,
  output logic [ROW_BYTES-1:0][DATA_W-1:0]  row_rd,
  input  logic                              commit_en,
  input  logic [ROW_W-1:0]                  commit_row,
  input  logic [ROW_BYTES-1:0][DATA_W-1:0]  commit_data,
  input  logic [ADDR_W-1:0]                 rd_addr,
  output logic [DATA_W-1:0]                 rd_data
);
  logic [ROW_BYTES-1:0][DATA_W-1:0] mem_q [ROWS];

  // row-wide write port, enabled only on the last busy cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < int'(ROWS); r++) begin
        mem_q[r] <= {ROW_BYTES{DATA_W'(ERASED)}};
      end
    end else if (commit_en) begin
      mem_q[commit_row] <= commit_data;
    end
  end

  assign row_rd  = mem_q[row_sel];
  assign rd_data = mem_q[rd_addr[ADDR_W-1:OFS_W]][rd_addr[OFS_W-1:0]];
endmodule

// File: rtl/nvrow_buffer.sv
module nvrow_buffer #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ROW_BYTES = 8,
  parameter int unsigned ROW_W     = 5,
  localparam int unsigned OFS_W    = $clog2(ROW_BYTES)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              load_en,
  input  logic [ROW_W-1:0]                  load_row,
  input  logic [ROW_BYTES-1:0][DATA_W-1:0]  load_data,
  input  logic                              byte_en,
  input  logic [OFS_W-1:0]                  byte_ofs,
  input  logic [DATA_W-1:0]                 byte_data,
  output logic [ROW_BYTES-1:0][DATA_W-1:0]  buf_q,
  output logic [ROW_W-1:0]                  row_q
);
  logic [ROW_BYTES-1:0][DATA_W-1:0] buf_d;
  logic [ROW_BYTES-1:0]             lane_hit;
  logic [ROW_W-1:0]                 row_d;
  logic                             buf_we;

  // per-lane merge: new byte wins over preload, preload wins over hold
  for (genvar i = 0; i < int'(ROW_BYTES); i++) begin : g_lane
    assign lane_hit[i] = byte_en && (byte_ofs == OFS_W'(i));
    assign buf_d[i]    = lane_hit[i] ? byte_data :
                         (load_en ? load_data[i] : buf_q[i]);

    // R2: a lane that is neither loaded nor addressed keeps its byte
    assert_lane_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !(byte_en && byte_ofs == OFS_W'(i))) |=> $stable(buf_q[i]));
  end

  assign buf_we = load_en | byte_en;
  assign row_d  = load_en ? load_row : row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      row_q <= '0;
    end else if (buf_we) begin
      buf_q <= buf_d;
      row_q <= row_d;
    end
  end

  // R2: the latched row changes only on the first byte of a transaction
  assert_row_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(row_q));
endmodule

// File: rtl/nvrow_timer.sv
module nvrow_timer #(
  parameter int unsigned WRITE_CYCLES = 20,
  localparam int unsigned CNT_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic last
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(WRITE_CYCLES - 1);
      cnt_en = 1'b1;
    end else if (busy_q) begin
      cnt_en = 1'b1;
      if (cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign last = busy_q && (cnt_q == '0);

  // checker-only run length counter for the busy window
  int unsigned chk_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    chk_run_q <= 0;
    else if (busy) chk_run_q <= chk_run_q + 1;
    else           chk_run_q <= 0;
  end

  // R5: busy ends after exactly WRITE_CYCLES cycles
  assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (chk_run_q == WRITE_CYCLES));
  // R5: busy never outlasts the write time
  assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (chk_run_q < WRITE_CYCLES));
endmodule

// File: rtl/nvrow_writer.sv
module nvrow_writer #(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned ROW_BYTES    = 8,
  parameter int unsigned WRITE_CYCLES = 20,
  parameter int unsigned ERASED       = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stop_pulse,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  import nvrow_pkg::*;

  localparam int unsigned OFS_W = $clog2(ROW_BYTES);
  localparam int unsigned ROW_W = ADDR_W - OFS_W;

  wr_state_e state_q, state_d;

  logic                             accept, load_en, start, last;
  logic [ROW_BYTES-1:0][DATA_W-1:0] row_rd, buf_q;
  logic [ROW_W-1:0]                 row_q;

  assign accept  = wr_stb && (state_q != ST_COMMIT);
  assign load_en = accept && (state_q == ST_IDLE);

  // next-state logic: a stop only commits once a byte has been taken
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) state_d = stop_pulse ? ST_COMMIT : ST_FILL;
      end
      ST_FILL: begin
        if (stop_pulse) state_d = ST_COMMIT;
      end
      ST_COMMIT: begin
        if (last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign start = (state_d == ST_COMMIT) && (state_q != ST_COMMIT);

  nvrow_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_BYTES(ROW_BYTES), .ERASED(ERASED)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .row_sel(wr_addr[ADDR_W-1:OFS_W]), .row_rd(row_rd),
    .commit_en(last), .commit_row(row_q), .commit_data(buf_q),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  nvrow_buffer #(
    .DATA_W(DATA_W), .ROW_BYTES(ROW_BYTES), .ROW_W(ROW_W)
  ) u_buffer (
    .clk(clk), .rst_n(rst_n),
    .load_en(load_en), .load_row(wr_addr[ADDR_W-1:OFS_W]), .load_data(row_rd),
    .byte_en(accept), .byte_ofs(wr_addr[OFS_W-1:0]), .byte_data(wr_data),
    .buf_q(buf_q), .row_q(row_q)
  );

  nvrow_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .last(last)
  );

  // R3: the controller state and the timer agree on the commit window
  assert_commit_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COMMIT) == busy);
  // R4: a stop with nothing buffered never raises busy
  assert_no_empty_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !wr_stb) |=> !busy);
  // R8: nothing reaches the row buffer during a commit
  assert_buffer_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(buf_q) && $stable(row_q)));
  // R5: busy rises right after a stop that closes a transaction
  assert_busy_follows_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL && stop_pulse) |=> busy);
endmodule

// File: tb/sim_nvrow_writer.sv
module sim_nvrow_writer;
  localparam int WT = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_stb, stop_pulse;
  logic [7:0] wr_addr, wr_data, rd_addr;
  logic [7:0] rd_data;
  logic       busy;

  always #10 clk = ~clk;

  nvrow_writer #(.WRITE_CYCLES(WT)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .stop_pulse(stop_pulse), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference model
  logic [7:0] m_mem [256];
  logic [7:0] m_buf [8];
  int         m_state;  // 0 idle, 1 collecting, 2 committing
  int         m_cnt;
  int         m_row;
  logic [7:0] probe;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) m_mem[i] = 8'hFF;
    for (int i = 0; i < 8; i++) m_buf[i] = 8'h00;
    m_state = 0; m_cnt = 0; m_row = 0;
  endtask

  task automatic model_step(input logic s, input logic [7:0] a, input logic [7:0] d,
                            input logic p);
    if (m_state == 2) begin
      if (m_cnt == 0) begin
        for (int i = 0; i < 8; i++) m_mem[m_row*8 + i] = m_buf[i];
        m_state = 0;
      end else begin
        m_cnt--;
      end
    end else begin
      if (s) begin
        if (m_state == 0) begin
          m_row = int'(a) / 8;
          for (int i = 0; i < 8; i++) m_buf[i] = m_mem[m_row*8 + i];
          m_state = 1;
        end
        m_buf[int'(a) % 8] = d;
      end
      if (p && m_state == 1) begin
        m_state = 2;
        m_cnt = WT - 1;
      end
    end
  endtask

  // one clock: drive, model on the edge, compare at the falling edge
  task automatic tick(input logic s, input logic [7:0] a, input logic [7:0] d,
                      input logic p);
    wr_stb = s; wr_addr = a; wr_data = d; stop_pulse = p; rd_addr = probe;
    @(posedge clk);
    model_step(s, a, d, p);
    @(negedge clk);
    chk(busy == (m_state == 2), "R5 busy vs model", int'(busy), int'(m_state == 2));
    chk(rd_data == m_mem[rd_addr], "R7 read vs model", int'(rd_data), int'(m_mem[rd_addr]));
    probe = probe + 8'd1;
  endtask

  task automatic idle();
    tick(1'b0, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy === 1'b1 && n < 1000) begin
      idle();
      n++;
    end
  endtask

  task automatic peek(input logic [7:0] a, input logic [7:0] exp, input string tag);
    wr_stb = 1'b0; stop_pulse = 1'b0; rd_addr = a;
    #1;
    chk(rd_data == exp, tag, int'(rd_data), int'(exp));
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 256; i++) peek(i[7:0], m_mem[i], tag);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; wr_stb = 1'b0; stop_pulse = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0; probe = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    sweep("R1 erased after reset");

    // single byte write, R5 length and R6 neighbours
    probe = 8'h10;
    tick(1'b1, 8'h13, 8'hA5, 1'b0);
    chk(busy == 1'b0, "R3 no busy before stop", int'(busy), 0);
    tick(1'b0, 8'h00, 8'h00, 1'b1);
    wait_idle(n);
    chk(n == WT, "R5 busy cycle count", n, WT);
    peek(8'h13, 8'hA5, "R6 written byte");
    peek(8'h12, 8'hFF, "R6 untouched neighbour");

    // full row write
    for (int i = 0; i < 8; i++) tick(1'b1, 8'h20 + i[7:0], 8'h30 + i[7:0], 1'b0);
    tick(1'b0, 8'h00, 8'h00, 1'b1);
    wait_idle(n);
    for (int i = 0; i < 8; i++) peek(8'h20 + i[7:0], 8'h30 + i[7:0], "R6 full row");

    // partial rewrite keeps the others
    tick(1'b1, 8'h22, 8'h5A, 1'b0);
    tick(1'b0, 8'h00, 8'h00, 1'b1);
    wait_idle(n);
    peek(8'h22, 8'h5A, "R2 merged byte");
    peek(8'h21, 8'h31, "R6 preserved byte");
    peek(8'h27, 8'h37, "R6 preserved byte end");

    // address-only transaction
    tick(1'b0, 8'h50, 8'h00, 1'b1);
    chk(busy == 1'b0, "R4 stop alone no busy", int'(busy), 0);
    idle();
    chk(busy == 1'b0, "R4 still idle", int'(busy), 0);

    // strobes and stop during busy are ignored
    tick(1'b1, 8'h40, 8'h77, 1'b1);
    tick(1'b1, 8'h48, 8'hEE, 1'b0);
    tick(1'b0, 8'h00, 8'h00, 1'b1);
    wait_idle(n);
    idle();
    chk(busy == 1'b0, "R8 stop during busy ignored", int'(busy), 0);
    peek(8'h48, 8'hFF, "R8 strobe during busy ignored");
    peek(8'h40, 8'h77, "R3 strobe with stop committed");

    // latched row: later bytes use only the offset
    tick(1'b1, 8'h3E, 8'h11, 1'b0);
    tick(1'b1, 8'h3F, 8'h22, 1'b0);
    tick(1'b1, 8'h40, 8'h33, 1'b0);
    tick(1'b0, 8'h00, 8'h00, 1'b1);
    wait_idle(n);
    peek(8'h3E, 8'h11, "R2 first byte");
    peek(8'h38, 8'h33, "R2 offset within latched row");
    peek(8'h40, 8'h77, "R2 other row untouched");

    // polling: accept right after busy falls
    tick(1'b1, 8'h50, 8'h01, 1'b1);
    wait_idle(n);
    tick(1'b1, 8'h51, 8'h02, 1'b1);
    chk(busy == 1'b1, "R9 strobe accepted after busy", int'(busy), 1);
    wait_idle(n);
    peek(8'h50, 8'h01, "R9 earlier row kept");
    peek(8'h51, 8'h02, "R9 new byte");

    // last value wins
    tick(1'b1, 8'h60, 8'h0A, 1'b0);
    tick(1'b1, 8'h60, 8'h0B, 1'b0);
    tick(1'b0, 8'h00, 8'h00, 1'b1);
    wait_idle(n);
    peek(8'h60, 8'h0B, "R10 overwrite same offset");

    // old data visible during busy, new data once low
    probe = 8'h70;
    tick(1'b1, 8'h70, 8'hC3, 1'b1);
    peek(8'h70, 8'hFF, "R7 old value while busy");
    wait_idle(n);
    peek(8'h70, 8'hC3, "R7 new value after busy");

    sweep("R6 final array");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule